// File: doc/BRIEF.md
# Indexed Per-Lane Edge Detector

This block watches a wide bus of monitored signals and raises a one-cycle event for every lane whose signal makes the kind of transition that lane was set up to catch. There are 256 lanes by default. Each lane can catch a low-to-high change, a high-to-low change, or any change. Each lane also has a suppress bit that silences its events.

Lanes are configured indirectly. A lane number is first written into a pointer register. Later writes of a 2-bit edge code or of a suppress bit then go to the lane that the pointer names. The pointer keeps its value until it is written again, so one pointer write can be followed by several data writes. Configuration can be read back as packed 32-bit words on a combinational read port. The edge codes fill 16 words and the suppress bits fill 8 words.

The monitored bus is sampled every clock. Each sample is compared with the one taken on the previous clock, and the per-lane result is registered. The block also produces a registered aggregate flag that is high when any lane has an event.

Top module: `lane_edge_bank`

## Requirements
- R1: While reset is held, every lane gets edge code 0 and suppress bit 0, all event outputs are 0, and the history register loads the bus value. In the first cycle after reset no event is reported, even when the bus is non-zero.
- R2: A pointer write (`ptr_we_i`) stores `ptr_i` and keeps it until the next pointer write. Every edge-code write and every suppress write goes to the lane that the stored pointer names.
- R3: Edge code 0 means rising. For a lane with code 0 and suppress bit 0, `evt_o[n]` goes high for one cycle, in the clock cycle after the edge that samples the bus with bit n going from 0 to 1. A 1-to-0 change on that lane gives no event.
- R4: Edge code 1 means falling. The lane reports a 1-to-0 change and ignores a 0-to-1 change.
- R5: Edge code 2 means toggle. The lane reports changes in both directions.
- R6: When a lane's suppress bit is 1, that lane never raises `evt_o`. Writing 0 to the suppress bit enables the lane again.
- R7: Edge code 3 is illegal. Writing it leaves the lane's code unchanged and makes `cfg_err_o` high for exactly the one cycle after the write.
- R8: With `rd_space_i`=0, `rd_addr_i`=w returns code word w (w from 0 to 15). Lane n is at bits [2*(n%16)+1 : 2*(n%16)] of word n/16.
- R9: With `rd_space_i`=1, `rd_addr_i`=w for w from 0 to 7 returns suppress word w, with lane n at bit n%32 of word n/32. Addresses 8 to 15 read as zero.
- R10: `any_evt_o` equals the OR of all bits of `evt_o` in every cycle.
- R11: A single change on a lane that is then held gives an event lasting exactly one cycle, and no more events follow while the bus holds still.
- R12: When a pointer write and an edge-code write happen in the same cycle, the code goes to the lane named by the old pointer, and the new pointer applies from the next write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_i | input | LANES | Monitored bus, one bit per lane |
| ptr_we_i | input | 1 | Lane pointer write strobe |
| ptr_i | input | PTR_W | Lane number to store in the pointer |
| code_we_i | input | 1 | Edge-code write strobe for the pointed lane |
| code_i | input | 2 | Edge code: 0 rising, 1 falling, 2 toggle, 3 rejected |
| sup_we_i | input | 1 | Suppress-bit write strobe for the pointed lane |
| sup_i | input | 1 | Suppress value: 1 silences the lane |
| rd_space_i | input | 1 | Read-back space: 0 edge codes, 1 suppress bits |
| rd_addr_i | input | RD_AW | Read-back word number |
| rd_data_o | output | WORD_W | Packed read-back word |
| evt_o | output | LANES | Registered per-lane event pulses |
| any_evt_o | output | 1 | Registered OR of all lane events |
| cfg_err_o | output | 1 | One-cycle pulse after a rejected edge-code write |

## Verification
The embedded assertions check four rules on every cycle:
- a suppressed lane never fires;
- the aggregate flag always matches the event vector;
- an event only follows an actual change of the bus between the two previous samples;
- the error pulse only follows an illegal-code write, and the pointer only moves on a pointer write.

Only the bench's scenarios can show the following:
- that each edge code selects the right polarity;
- that a write lands on the pointed lane, including when the pointer is written in the same cycle;
- that rejected codes leave the stored code intact;
- that the packed read-back places every lane at the stated bit position.

// File: rtl/leb_pkg.sv
// Shared definitions for the indexed per-lane edge detector.
// Assumes: the edge code is 2 bits wide and 3 is the only illegal value.
package leb_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_ANY  = 2'd2,
        EDGE_BAD  = 2'd3
    } edge_code_t;

    localparam int CODE_W = 2;
endpackage

// File: rtl/leb_cfg.sv
// Configuration store: lane pointer, per-lane edge codes and suppress bits.
// A write of an edge code or a suppress bit goes to the lane named by the
// pointer value held before the current cycle. An illegal code is dropped
// and flagged for one cycle.
// Assumes: LANES is a power of two, so every pointer value names a lane.
module leb_cfg
    import leb_pkg::*;
#(
    parameter int LANES = 256,
    parameter int PTR_W = $clog2(LANES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ptr_we,
    input  logic [PTR_W-1:0]              ptr_wdata,
    input  logic                          code_we,
    input  logic [CODE_W-1:0]             code_wdata,
    input  logic                          sup_we,
    input  logic                          sup_wdata,
    output logic [LANES-1:0][CODE_W-1:0]  lane_code,
    output logic [LANES-1:0]              lane_sup,
    output logic                          cfg_err
);
    logic [PTR_W-1:0] ptr_q;
    logic             code_ok;

    assign code_ok = (code_wdata != EDGE_BAD);

    // Holds the lane pointer until software writes a new one.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (ptr_we) ptr_q <= ptr_wdata;
    end

    // Pulses the error flag for one cycle after an illegal code write.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= code_we && !code_ok;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = (ptr_q == PTR_W'(g));

        // Stores this lane's edge code; illegal codes are dropped.
        always_ff @(posedge clk) begin
            if (!rst_n)                        lane_code[g] <= EDGE_RISE;
            else if (code_we && hit && code_ok) lane_code[g] <= code_wdata;
        end

        // Stores this lane's suppress bit.
        always_ff @(posedge clk) begin
            if (!rst_n)            lane_sup[g] <= 1'b0;
            else if (sup_we && hit) lane_sup[g] <= sup_wdata;
        end
    end

    // R7
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(code_we && (code_wdata == EDGE_BAD)));

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |=> $stable(ptr_q));
endmodule

// File: rtl/leb_detect.sv
// Edge detection: keeps the previous bus sample and compares the live bus
// with it. The per-lane hits, after suppression, are registered as event
// pulses together with an aggregate flag.
// Assumes: lane_code never holds 3 (the config store rejects it).
module leb_detect
    import leb_pkg::*;
#(
    parameter int LANES = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              mon,
    input  logic [LANES-1:0][CODE_W-1:0]  lane_code,
    input  logic [LANES-1:0]              lane_sup,
    output logic [LANES-1:0]              evt,
    output logic                          any_evt
);
    logic [LANES-1:0] hist_q;
    logic [LANES-1:0] rise_v;
    logic [LANES-1:0] fall_v;
    logic [LANES-1:0] hit_v;

    // Samples the bus every clock; reset also loads the live value.
    always_ff @(posedge clk) begin
        hist_q <= mon;
    end

    assign rise_v = mon & ~hist_q;
    assign fall_v = ~mon & hist_q;

    for (genvar g = 0; g < LANES; g++) begin : g_hit
        // Selects the transition this lane reports and applies suppression.
        assign hit_v[g] = !lane_sup[g] &&
            (((lane_code[g] == EDGE_RISE) && rise_v[g]) ||
             ((lane_code[g] == EDGE_FALL) && fall_v[g]) ||
             ((lane_code[g] == EDGE_ANY)  && (rise_v[g] || fall_v[g])));
    end

    // Registers the per-lane events and the aggregate flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt     <= '0;
            any_evt <= 1'b0;
        end else begin
            evt     <= hit_v;
            any_evt <= |hit_v;
        end
    end

    // R6
    sup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & $past(lane_sup)) == '0);

    // R10
    any_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt == (|evt));
endmodule

// File: rtl/leb_readback.sv
// Packed read-back: shows the edge codes as 32-bit words holding 16 lanes
// each, and the suppress bits as words holding 32 lanes each.
// Suppress words past the last one read as zero.
// Assumes: 2*LANES and LANES are multiples of WORD_W.
module leb_readback
    import leb_pkg::*;
#(
    parameter int LANES  = 256,
    parameter int WORD_W = 32,
    parameter int RD_AW  = $clog2((LANES * CODE_W) / WORD_W)
) (
    input  logic [LANES-1:0][CODE_W-1:0]  lane_code,
    input  logic [LANES-1:0]              lane_sup,
    input  logic                          rd_space,
    input  logic [RD_AW-1:0]              rd_addr,
    output logic [WORD_W-1:0]             rd_data
);
    localparam int CODE_WORDS = (LANES * CODE_W) / WORD_W;
    localparam int SUP_WORDS  = LANES / WORD_W;
    localparam int SUP_AW     = (SUP_WORDS > 1) ? $clog2(SUP_WORDS) : 1;

    logic [LANES*CODE_W-1:0] code_flat;
    logic [WORD_W-1:0]       code_words [CODE_WORDS];
    logic [WORD_W-1:0]       sup_words  [SUP_WORDS];
    logic                    sup_in_range;

    assign code_flat    = lane_code;
    assign sup_in_range = (32'(rd_addr) < SUP_WORDS);

    for (genvar w = 0; w < CODE_WORDS; w++) begin : g_cw
        assign code_words[w] = code_flat[w*WORD_W +: WORD_W];
    end

    for (genvar w = 0; w < SUP_WORDS; w++) begin : g_sw
        assign sup_words[w] = lane_sup[w*WORD_W +: WORD_W];
    end

    // Selects the addressed word in the chosen space.
    always_comb begin
        if (!rd_space)          rd_data = code_words[rd_addr];
        else if (sup_in_range)  rd_data = sup_words[rd_addr[SUP_AW-1:0]];
        else                    rd_data = '0;
    end
endmodule

// File: rtl/lane_edge_bank.sv
// Top of the indexed per-lane edge detector. Joins the configuration
// store, the detector and the packed read-back.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module lane_edge_bank
    import leb_pkg::*;
#(
    parameter int LANES  = 256,
    parameter int WORD_W = 32,
    parameter int PTR_W  = $clog2(LANES),
    parameter int RD_AW  = $clog2((LANES * CODE_W) / WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   mon_i,
    input  logic               ptr_we_i,
    input  logic [PTR_W-1:0]   ptr_i,
    input  logic               code_we_i,
    input  logic [1:0]         code_i,
    input  logic               sup_we_i,
    input  logic               sup_i,
    input  logic               rd_space_i,
    input  logic [RD_AW-1:0]   rd_addr_i,
    output logic [WORD_W-1:0]  rd_data_o,
    output logic [LANES-1:0]   evt_o,
    output logic               any_evt_o,
    output logic               cfg_err_o
);
    logic [LANES-1:0][CODE_W-1:0] lane_code;
    logic [LANES-1:0]             lane_sup;

    leb_cfg #(.LANES(LANES), .PTR_W(PTR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_we     (ptr_we_i),
        .ptr_wdata  (ptr_i),
        .code_we    (code_we_i),
        .code_wdata (code_i),
        .sup_we     (sup_we_i),
        .sup_wdata  (sup_i),
        .lane_code  (lane_code),
        .lane_sup   (lane_sup),
        .cfg_err    (cfg_err_o)
    );

    leb_detect #(.LANES(LANES)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon       (mon_i),
        .lane_code (lane_code),
        .lane_sup  (lane_sup),
        .evt       (evt_o),
        .any_evt   (any_evt_o)
    );

    leb_readback #(.LANES(LANES), .WORD_W(WORD_W), .RD_AW(RD_AW)) u_rb (
        .lane_code (lane_code),
        .lane_sup  (lane_sup),
        .rd_space  (rd_space_i),
        .rd_addr   (rd_addr_i),
        .rd_data   (rd_data_o)
    );

    // Counts clocks since reset so the history check only looks at valid samples.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R11
    evt_needs_change_chk: assert property (@(posedge clk)
        disable iff (!rst_n || (warm_q != 2'd2))
        (|evt_o) |-> ($past(mon_i) != $past(mon_i, 2)));
endmodule

// File: tb/sim_lane_edge_bank.sv
module sim_lane_edge_bank;
    localparam int LANES  = 256;
    localparam int WORD_W = 32;
    localparam int PTR_W  = 8;
    localparam int RD_AW  = 4;
    localparam int NV     = 10;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [LANES-1:0]   mon;
    logic               ptr_we, code_we, sup_we, sup, rd_space;
    logic [PTR_W-1:0]   ptr;
    logic [1:0]         code;
    logic [RD_AW-1:0]   rd_addr;
    logic [WORD_W-1:0]  rd_data;
    logic [LANES-1:0]   evt;
    logic               any_evt, cfg_err;

    int n_run = 0;
    int n_fail = 0;
    logic [1:0] m_code [LANES];
    logic       m_sup  [LANES];
    int         cur_ptr;

    always #2 clk = ~clk;

    lane_edge_bank u0 (
        .clk(clk), .rst_n(rst_n), .mon_i(mon),
        .ptr_we_i(ptr_we), .ptr_i(ptr), .code_we_i(code_we), .code_i(code),
        .sup_we_i(sup_we), .sup_i(sup), .rd_space_i(rd_space), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .evt_o(evt), .any_evt_o(any_evt), .cfg_err_o(cfg_err)
    );

    // vector: lane[15:8] code[7:6] sup[5] old[4] new[3] expect[2]
    function automatic logic [15:0] pk(int ln, int cd, int sp, int o, int n, int e);
        return {8'(ln), 2'(cd), 1'(sp), 1'(o), 1'(n), 1'(e), 2'b00};
    endfunction

    localparam logic [15:0] TBL [NV] = '{
        pk(5,   0, 0, 0, 1, 1), pk(5,   0, 0, 1, 0, 0),
        pk(200, 1, 0, 1, 0, 1), pk(200, 1, 0, 0, 1, 0),
        pk(31,  2, 0, 0, 1, 1), pk(31,  2, 0, 1, 0, 1),
        pk(32,  2, 1, 0, 1, 0), pk(255, 0, 1, 0, 1, 0),
        pk(0,   1, 0, 1, 0, 1), pk(32,  2, 0, 1, 0, 1)
    };

    task automatic check(input string req, input string what,
                         input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_ptr(input int i);
        ptr_we = 1'b1; ptr = 8'(i);
        @(negedge clk);
        ptr_we = 1'b0;
        cur_ptr = i;
    endtask

    task automatic wr_code(input int c, output logic err);
        code_we = 1'b1; code = 2'(c);
        @(negedge clk);
        code_we = 1'b0;
        err = cfg_err;
        if (c != 3) m_code[cur_ptr] = 2'(c);
    endtask

    task automatic wr_sup(input int s);
        sup_we = 1'b1; sup = 1'(s);
        @(negedge clk);
        sup_we = 1'b0;
        m_sup[cur_ptr] = 1'(s);
    endtask

    function automatic logic [WORD_W-1:0] exp_code_word(input int w);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < 16; k++) r[2*k +: 2] = m_code[w*16 + k];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] exp_sup_word(input int w);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < 32; k++) r[k] = m_sup[w*32 + k];
        return r;
    endfunction

    task automatic rd(input logic sp, input int a, output logic [WORD_W-1:0] d);
        rd_space = sp; rd_addr = 4'(a);
        #1;
        d = rd_data;
    endtask

    task automatic settle(input logic [LANES-1:0] v);
        mon = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] d;
        logic err;
        logic [LANES-1:0] e;
        for (int i = 0; i < LANES; i++) begin
            m_code[i] = 2'd0; m_sup[i] = 1'b0;
        end
        cur_ptr = 0;
        rst_n = 1'b0; mon = '1;
        ptr_we = 0; code_we = 0; sup_we = 0; sup = 0; ptr = '0; code = '0;
        rd_space = 0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no event right after reset though the bus is all ones
        check("R1", "evt after reset", evt, '0);
        check("R1", "any after reset", LANES'(any_evt), '0);
        check("R1", "err after reset", LANES'(cfg_err), '0);
        for (int w = 0; w < 16; w++) begin
            rd(1'b0, w, d); check("R1", "code word reset", LANES'(d), '0);
        end
        for (int w = 0; w < 8; w++) begin
            rd(1'b1, w, d); check("R1", "sup word reset", LANES'(d), '0);
        end
        // R3: default rising ignores a falling bus, then catches a rising bus
        mon = '0; @(negedge clk);
        check("R3", "fall on rising lanes", evt, '0);
        mon = '1; @(negedge clk);
        check("R3", "all lanes rise", evt, '1);
        check("R10", "any on all rise", LANES'(any_evt), LANES'(1));
        settle('0);

        // table walk: R3 R4 R5 R6
        for (int t = 0; t < NV; t++) begin
            int ln;
            string rq;
            ln = int'(TBL[t][15:8]);
            wr_ptr(ln);
            wr_code(int'(TBL[t][7:6]), err);
            wr_sup(int'(TBL[t][5]));
            e = '0; e[ln] = TBL[t][4];
            settle(e);
            mon[ln] = TBL[t][3];
            @(negedge clk);
            e = '0; e[ln] = TBL[t][2];
            if (TBL[t][5] || t == NV-1) rq = "R6";
            else if (TBL[t][7:6] == 2'd0) rq = "R3";
            else if (TBL[t][7:6] == 2'd1) rq = "R4";
            else rq = "R5";
            check(rq, $sformatf("table entry %0d evt", t), evt, e);
            check("R10", $sformatf("table entry %0d any", t), LANES'(any_evt), LANES'(TBL[t][2]));
        end
        settle('0);

        // R7: illegal code dropped, error pulses for one cycle
        wr_ptr(7);
        wr_code(2, err);
        check("R7", "no err on legal code", LANES'(err), '0);
        wr_code(3, err);
        check("R7", "err pulse on code 3", LANES'(err), LANES'(1));
        @(negedge clk);
        check("R7", "err pulse one cycle", LANES'(cfg_err), '0);
        rd(1'b0, 0, d);
        check("R7", "code kept after reject", LANES'(d), LANES'(exp_code_word(0)));

        // R12: pointer and code written together use the old pointer
        wr_ptr(9);
        ptr_we = 1'b1; ptr = 8'd40; code_we = 1'b1; code = 2'd1;
        @(negedge clk);
        ptr_we = 1'b0; code_we = 1'b0;
        m_code[9] = 2'd1; cur_ptr = 40;
        rd(1'b0, 0, d);
        check("R12", "old pointer lane written", LANES'(d), LANES'(exp_code_word(0)));
        rd(1'b0, 2, d);
        check("R12", "new pointer lane untouched", LANES'(d), LANES'(exp_code_word(2)));

        // R2: pointer persists over several data writes
        wr_code(2, err);
        wr_sup(1);
        rd(1'b0, 2, d);
        check("R2", "code to held pointer", LANES'(d), LANES'(exp_code_word(2)));
        rd(1'b1, 1, d);
        check("R2", "sup to held pointer", LANES'(d), LANES'(exp_sup_word(1)));

        // R8 / R9: full packed read-back
        for (int w = 0; w < 16; w++) begin
            rd(1'b0, w, d);
            check("R8", $sformatf("code word %0d", w), LANES'(d), LANES'(exp_code_word(w)));
        end
        for (int w = 0; w < 16; w++) begin
            rd(1'b1, w, d);
            check("R9", $sformatf("sup word %0d", w), LANES'(d),
                  (w < 8) ? LANES'(exp_sup_word(w)) : '0);
        end

        // R11: held change gives a single pulse
        settle('0);
        mon[5] = 1'b1;
        @(negedge clk);
        e = '0; e[5] = 1'b1;
        check("R11", "first pulse", evt, e);
        @(negedge clk);
        check("R11", "pulse ends", evt, '0);
        @(negedge clk);
        check("R11", "stays quiet", evt, '0);

        // R10 / R6: several lanes at once, one suppressed
        settle('0);
        wr_ptr(32); wr_sup(1);
        mon[5] = 1'b1; mon[31] = 1'b1; mon[32] = 1'b1;
        @(negedge clk);
        e = '0; e[5] = 1'b1; e[31] = 1'b1;
        check("R6", "multi lane with suppressed lane", evt, e);
        check("R10", "any on multi lane", LANES'(any_evt), LANES'(1));
        @(negedge clk);
        check("R10", "any clears", LANES'(any_evt), '0);

        summary();
        $finish;
    end
endmodule